// File: doc/BRIEF.md
# Multi-Mode Four-Input Lookup Element

This block is a reconfigurable logic element built around one 16-bit store addressed by four select inputs. Depending on a two-bit mode input the same store behaves as a truth-table function generator, as a 16-deep by 1-bit memory with a write port, or as a 16-stage serial shift register whose taps can be read by address. A parallel configuration port loads all 16 bits at once in any mode, so any of the 65,536 four-input functions can be set up in a single clock.

The select inputs form an address in which `selA` is the most significant bit and `selD` the least significant bit. Row 0000 reads store bit 0 and row 1111 reads store bit 15. The addressed bit always drives `lutOut` through combinational logic. Store bit 15 always drives `cascadeOut`, so a shift chain can be extended into a neighbouring element.

Top module: `multi_lut4`

## Requirements
- R1: An active-low asynchronous reset (`rstN` low) clears all 16 store bits, so `lutOut` and `cascadeOut` read 0 at every address.
- R2: In logic mode (`modeSel` = 2'b00), `lutOut` equals store bit number {selA,selB,selC,selD}, with selA as the MSB. Row 0000 is bit 0 and row 1111 is bit 15.
- R3: When `cfgLoad` is high at a rising clock edge, store bit i takes `cfgData[i]` for all 16 bits. This happens in every mode and takes priority over a RAM write or a shift in the same cycle.
- R4: In logic mode, `wrEn` and `shiftEn` leave the store unchanged. Only a configuration load alters it.
- R5: In RAM mode (`modeSel` = 2'b01), a rising edge with `wrEn` high writes `wrData` into bit {selA,selB,selC,selD}. All other bits keep their values.
- R6: Reads are combinational. A change of the select inputs shows on `lutOut` without any clock edge, and a bit written at an edge can be read right after that edge.
- R7: In shift mode (`modeSel` = 2'b10), a rising edge with `shiftEn` high moves bit i into bit i+1 for i = 0..14 and loads `shiftIn` into bit 0.
- R8: `cascadeOut` always equals store bit 15, in every mode.
- R9: The reserved mode 2'b11 behaves as logic mode: writes and shifts have no effect.
- R10: An enable that belongs to another mode has no effect. `shiftEn` is ignored in RAM mode, `wrEn` is ignored in shift mode, and with `shiftEn` low the shift register holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | 00 logic, 01 RAM, 10 shift, 11 reserved (acts as logic) |
| selA | input | 1 | Select bit, address MSB |
| selB | input | 1 | Select bit |
| selC | input | 1 | Select bit |
| selD | input | 1 | Select bit, address LSB |
| cfgLoad | input | 1 | Parallel configuration load strobe |
| cfgData | input | 16 | Configuration pattern, bit i goes to row i |
| wrEn | input | 1 | RAM write enable |
| wrData | input | 1 | RAM write data |
| shiftEn | input | 1 | Shift enable |
| shiftIn | input | 1 | Serial data into bit 0 |
| lutOut | output | 1 | Addressed store bit |
| cascadeOut | output | 1 | Store bit 15 |

## Verification
The embedded properties check on every cycle that a load copies the whole pattern, that a RAM write changes at most the addressed bit, that a shift moves every stage by one place, and that the store is frozen when no strobe is active. They also check that the control never raises two store strobes at once and that `cascadeOut` stays still in logic and reserved modes. Only the bench scenarios show the address bit order of the read path, the combinational read without a clock, the reset clearing the store in the middle of a run, and the values that come out after sequences of writes and shifts.

// File: rtl/lut4_pkg.sv
package lut4_pkg;

  localparam int unsigned LUT_INPUTS = 4;
  localparam int unsigned LUT_DEPTH  = 1 << LUT_INPUTS;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_RAM   = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_RSVD  = 2'b11
  } lutMode_e;

  // Strobes from control to the storage datapath; at most one is high.
  typedef struct packed {
    logic load;
    logic write;
    logic shift;
  } storeCtl_t;

endpackage

// File: rtl/lut4_ctrl.sv
module lut4_ctrl
  import lut4_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       cfgLoad,
  input  logic       wrEn,
  input  logic       shiftEn,
  output storeCtl_t  strb
);

  lutMode_e modeNow;
  logic     isRam;
  logic     isShift;

  always_comb begin
    modeNow = lutMode_e'(modeSel);
    isRam   = 1'b0;
    isShift = 1'b0;
    unique case (modeNow)
      MODE_RAM:   isRam   = 1'b1;
      MODE_SHIFT: isShift = 1'b1;
      default: begin
        // logic and reserved modes leave the store alone
        isRam   = 1'b0;
        isShift = 1'b0;
      end
    endcase
  end

  // configuration load wins over any mode-specific update
  always_comb begin
    strb.load  = cfgLoad;
    strb.write = !cfgLoad && isRam   && wrEn;
    strb.shift = !cfgLoad && isShift && shiftEn;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.write, strb.shift})); // R3

  AST_LOGIC_NO_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 || modeSel == 2'b11) |-> !(strb.write || strb.shift)); // R9

endmodule

// File: rtl/lut4_store.sv
module lut4_store
  import lut4_pkg::*;
#(
  parameter int unsigned SEL_W = LUT_INPUTS,
  localparam int unsigned DEPTH = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  storeCtl_t        strb,
  input  logic [SEL_W-1:0] addr,
  input  logic [DEPTH-1:0] cfgData,
  input  logic             wrData,
  input  logic             shiftIn,
  output logic             rdBit,
  output logic             tailBit
);

  logic [DEPTH-1:0] bits;
  logic [DEPTH-1:0] nextBits;

  // per-row next-state selection: load, then write, then shift, else hold
  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic wrHit;
    logic shiftSrc;

    assign wrHit = strb.write && (addr == SEL_W'(i));

    if (i == 0) begin : g_head
      assign shiftSrc = shiftIn;
    end else begin : g_body
      assign shiftSrc = bits[i-1];
    end

    always_comb begin
      if (strb.load) begin
        nextBits[i] = cfgData[i];
      end else if (wrHit) begin
        nextBits[i] = wrData;
      end else if (strb.shift) begin
        nextBits[i] = shiftSrc;
      end else begin
        nextBits[i] = bits[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bits <= '0;
    end else begin
      bits <= nextBits;
    end
  end

  assign rdBit   = bits[addr];
  assign tailBit = bits[DEPTH-1];

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (bits == $past(cfgData))); // R3

  AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |=> (bits[$past(addr)] == $past(wrData))); // R5

  AST_RAM_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |=> ($countones(bits ^ $past(bits)) <= 1)); // R5

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (bits == {$past(bits[DEPTH-2:0]), $past(shiftIn)})); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.write || strb.shift) |=> $stable(bits)); // R4

endmodule

// File: rtl/multi_lut4.sv
module multi_lut4
  import lut4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           modeSel,
  input  logic                 selA,
  input  logic                 selB,
  input  logic                 selC,
  input  logic                 selD,
  input  logic                 cfgLoad,
  input  logic [LUT_DEPTH-1:0] cfgData,
  input  logic                 wrEn,
  input  logic                 wrData,
  input  logic                 shiftEn,
  input  logic                 shiftIn,
  output logic                 lutOut,
  output logic                 cascadeOut
);

  storeCtl_t             strb;
  logic [LUT_INPUTS-1:0] addr;

  // selA is the address MSB, selD the LSB
  assign addr = {selA, selB, selC, selD};

  lut4_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .cfgLoad (cfgLoad),
    .wrEn    (wrEn),
    .shiftEn (shiftEn),
    .strb    (strb)
  );

  lut4_store #(
    .SEL_W (LUT_INPUTS)
  ) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .cfgData (cfgData),
    .wrData  (wrData),
    .shiftIn (shiftIn),
    .rdBit   (lutOut),
    .tailBit (cascadeOut)
  );

  AST_LOGIC_CASCADE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel == 2'b00 || modeSel == 2'b11) && !cfgLoad) |=> $stable(cascadeOut)); // R4

endmodule

// File: tb/multi_lut4_bench.sv
module multi_lut4_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] PAT = 16'hA5C3;
  localparam int NVEC = 14;

  // entry: {mode[1:0], addr[3:0], {ld,wr,wd,sh,si}, {expOut,expCasc}, 3'b0}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 4'd0,  5'b10000, 2'b11, 3'b0}, // R3 load pattern
    {2'd0, 4'd2,  5'b00000, 2'b01, 3'b0}, // R2
    {2'd0, 4'd6,  5'b00000, 2'b11, 3'b0}, // R2
    {2'd0, 4'd13, 5'b01010, 2'b11, 3'b0}, // R4 write/shift ignored
    {2'd3, 4'd9,  5'b01111, 2'b01, 3'b0}, // R9 reserved mode
    {2'd1, 4'd9,  5'b01100, 2'b11, 3'b0}, // R5 write 1
    {2'd1, 4'd15, 5'b01000, 2'b00, 3'b0}, // R5 R8 write 0 to bit 15
    {2'd1, 4'd8,  5'b00010, 2'b10, 3'b0}, // R10 shift in RAM mode
    {2'd2, 4'd14, 5'b01100, 2'b00, 3'b0}, // R10 write in shift mode
    {2'd2, 4'd15, 5'b00010, 2'b00, 3'b0}, // R7 shift in 0
    {2'd2, 4'd0,  5'b00011, 2'b11, 3'b0}, // R7 R8 shift in 1
    {2'd2, 4'd1,  5'b00000, 2'b01, 3'b0}, // R10 hold
    {2'd2, 4'd3,  5'b10011, 2'b01, 3'b0}, // R3 load beats shift
    {2'd1, 4'd4,  5'b11100, 2'b01, 3'b0}  // R3 load beats write
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [3:0]  addr = 4'd0;
  logic        cfgLoad = 1'b0;
  logic [15:0] cfgData = PAT;
  logic        wrEn = 1'b0;
  logic        wrData = 1'b0;
  logic        shiftEn = 1'b0;
  logic        shiftIn = 1'b0;
  logic        lutOut;
  logic        cascadeOut;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multi_lut4 u_multi_lut4 (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .selA       (addr[3]),
    .selB       (addr[2]),
    .selC       (addr[1]),
    .selD       (addr[0]),
    .cfgLoad    (cfgLoad),
    .cfgData    (cfgData),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .shiftEn    (shiftEn),
    .shiftIn    (shiftIn),
    .lutOut     (lutOut),
    .cascadeOut (cascadeOut)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    cfgLoad = 1'b0; wrEn = 1'b0; wrData = 1'b0; shiftEn = 1'b0; shiftIn = 1'b0;
  endtask

  // sweep every address in logic mode without clocking
  task automatic sweep(input string req, input logic [15:0] expBits);
    modeSel = 2'b00;
    idleInputs();
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      #1;
      check(req, {lutOut, cascadeOut}, {expBits[a], expBits[15]});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 in reset", {lutOut, cascadeOut}, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    sweep("R1 after reset", 16'h0000);

    // table walk: drive at negedge, clock, sample at next negedge
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      modeSel = VEC[v][15:14];
      addr    = VEC[v][13:10];
      cfgLoad = VEC[v][9];
      wrEn    = VEC[v][8];
      wrData  = VEC[v][7];
      shiftEn = VEC[v][6];
      shiftIn = VEC[v][5];
      @(negedge clk);
      check($sformatf("R2 R3 R4 R5 R7 R8 R9 R10 vector %0d", v),
            {lutOut, cascadeOut}, VEC[v][4:3]);
      idleInputs();
    end

    // R6 combinational read of full pattern, R2 bit ordering
    sweep("R6 R2 sweep after loads", PAT);

    // R5 single write leaves other rows intact
    @(negedge clk);
    modeSel = 2'b01; addr = 4'd5; wrEn = 1'b1; wrData = 1'b1;
    @(negedge clk);
    check("R6 read right after write", {lutOut, cascadeOut}, 2'b11);
    sweep("R5 other rows unchanged", PAT | 16'h0020);

    // R7 full shift of ones then R8 cascade
    @(negedge clk);
    modeSel = 2'b10; addr = 4'd0; cfgLoad = 1'b1; cfgData = 16'h0000;
    @(negedge clk);
    cfgLoad = 1'b0; shiftEn = 1'b1; shiftIn = 1'b1;
    repeat (15) @(negedge clk);
    check("R8 cascade before 16th shift", {lutOut, cascadeOut}, 2'b10);
    @(negedge clk);
    check("R7 R8 after 16 shifts", {lutOut, cascadeOut}, 2'b11);
    idleInputs();
    sweep("R7 all ones", 16'hFFFF);

    // R1 reset in the middle of a run
    rstN = 1'b0;
    #1;
    sweep("R1 mid-run reset", 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {lutOut, cascadeOut}, 2'b00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule